// File: doc/BRIEF.md
# Packet-to-Cell Splitter

The block sits at the ingress of a two-stage multipath switch. Packets arrive one byte per cycle on an 8-bit bus. A 2-bit control code travels beside each byte. The block cuts each packet into cells that all carry exactly 128 payload bytes, and puts eight header bytes in front of every cell. A final cell that is only partly filled is completed with a fixed filler byte. The headers carry the following:

- a middle-group tag, which sends the cell through the load-balancing stage;
- the output group, which the forwarding stage uses;
- a reassembly header: input group, line number, sequence number and end-of-packet mark;
- a splitting header: cell length, full-cell count, filler flag and filler count.

A packet is accepted only as a whole into a byte FIFO. The full-cell and filler counts appear in every cell of the packet, so the whole length must be known before the first cell leaves. An output state machine then streams the packet's cells back to back, 136 bytes each, with no gap. The middle-group tag and the line number rotate from cell to cell. They do not restart at a packet boundary, so consecutive cells of the whole stream spread evenly over the middle groups.

Top module: `cell_splitter`

## Requirements
- R1: An input packet starts with a lookup byte carried with code 11. Its bits [6:4] give the output group and bits [3:0] the priority. Payload bytes follow with code 00, and the final payload byte carries code 10. Bytes with code 01, and bytes that arrive outside a packet, are dropped.
- R2: Each emitted cell is exactly 136 consecutive valid bytes. Byte 0 carries code 11, bytes 1 to 7 carry code 01, bytes 8 to 134 carry code 00 and byte 135 carries code 10.
- R3: in_ready is high only when the payload FIFO has room for at least 128 more bytes and no completed packet is waiting for the output side. The FIFO never overflows or underflows.
- R4: Header byte 0 is {1, middle-group tag (3 bits), priority}. The tag advances by one per cell modulo MID_GROUPS and continues across packet boundaries.
- R5: Header byte 1 is {1, output group (3 bits), priority}.
- R6: Header byte 2 is {in_group, line (4 bits)}. The line number advances by one per cell modulo LINES and continues across packets.
- R7: Header byte 3 is {sequence (6 bits), end-of-packet, 0}. The sequence is 1 for the first cell of each packet, and end-of-packet is set only on the packet's final cell.
- R8: Header bytes 4 to 7 are {in_group, length[10:7]}, {length[6:0], filler flag}, {full cells (5 bits), filler[10:8]} and {filler[7:0]}. Length is 128. Full cells is the packet length divided by 128, rounded down. The filler count is the number of filler bytes in the last cell, and the flag is set when that count is non-zero.
- R9: The payload bytes appear in input order. A packet of L bytes yields ceil(L/128) cells, and positions past L in its last cell carry 0xEE.
- R10: Reset clears out_valid, empties the FIFO, raises in_ready, and restarts both the tag and the line number at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_group | input | 4 | Input-group number placed in the headers |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ctrl | input | 2 | Input control code |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output cell byte |
| out_ctrl | output | 2 | Output control code |

## Verification
The bench builds the block with a 1024-byte FIFO, a 896-byte packet limit, four middle groups and six lines. Four is a power of two, so the tag takes the plain wrap-around counter. Six is not, so the line number takes the compare-and-clear counter, and the 0..5 rotation shows up in the headers. The small FIFO and the back-to-back packets let a completed packet wait behind a 5-cell packet that is still being emitted, which drives in_ready low. The packet lengths cover exact multiples of 128, a single byte, 128+1 bytes and the two padded lengths 70 and 429.

// File: rtl/cell_splitter_pkg.sv
package cell_splitter_pkg;
   localparam int unsigned CELL_BYTES = 128;
   localparam int unsigned HDR_BYTES  = 8;
   localparam int unsigned CELL_WIRE  = CELL_BYTES + HDR_BYTES;
   localparam int unsigned LEN_W      = 12;
   localparam logic [7:0]  FILL_BYTE  = 8'hEE;

   typedef enum logic [1:0] {
      CT_PAY = 2'b00,
      CT_HDR = 2'b01,
      CT_END = 2'b10,
      CT_SOP = 2'b11
   } ctrl_e;

   typedef struct packed {
      logic [2:0]       og;
      logic [3:0]       prio;
      logic [LEN_W-1:0] len;
   } pkt_desc_t;
endpackage

// File: rtl/cell_byte_fifo.sv
module cell_byte_fifo #(
   parameter  int unsigned DEPTH = 2048,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [7:0]  wr_data,
   input  logic        rd_en,
   output logic [7:0]  rd_data,
   output logic [AW:0] free
);
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   used;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp   <= '0;
         rp   <= '0;
         used <= '0;
      end else begin
         if (wr_en) wp <= wp + 1'b1;
         if (rd_en) rp <= rp + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   used <= used + 1'b1;
            2'b01:   used <= used - 1'b1;
            default: ;
         endcase
      end
   end

   assign rd_data = mem[rp];
   assign free    = (AW+1)'(DEPTH) - used;
endmodule

// File: rtl/pkt_ingress.sv
module pkt_ingress
   import cell_splitter_pkg::*;
#(
   parameter int unsigned FREE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   input  logic [1:0]        in_ctrl,
   output logic              in_ready,
   input  logic [FREE_W-1:0] fifo_free,
   output logic              wr_en,
   output logic [7:0]        wr_data,
   input  logic              take,
   output logic              desc_valid,
   output pkt_desc_t         desc
);
   logic             in_pkt;
   logic [LEN_W-1:0] cnt;
   logic             fire;
   ctrl_e            ct;

   assign ct       = ctrl_e'(in_ctrl);
   assign in_ready = (fifo_free >= FREE_W'(CELL_BYTES)) && !desc_valid;
   assign fire     = in_valid && in_ready;
   assign wr_en    = fire && in_pkt && (ct == CT_PAY || ct == CT_END);
   assign wr_data  = in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt     <= 1'b0;
         cnt        <= '0;
         desc_valid <= 1'b0;
         desc       <= '0;
      end else begin
         if (take) desc_valid <= 1'b0;
         if (fire && !in_pkt && ct == CT_SOP) begin
            in_pkt    <= 1'b1;
            cnt       <= '0;
            desc.og   <= in_data[6:4];
            desc.prio <= in_data[3:0];
         end
         if (wr_en) begin
            cnt <= cnt + 1'b1;
            if (ct == CT_END) begin
               in_pkt     <= 1'b0;
               desc_valid <= 1'b1;
               desc.len   <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cell_egress.sv
module cell_egress
   import cell_splitter_pkg::*;
#(
   parameter  int unsigned MID_GROUPS = 4,
   parameter  int unsigned LINES      = 8,
   localparam int unsigned TAG_W      = $clog2(MID_GROUPS),
   localparam int unsigned LINE_W     = $clog2(LINES)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] in_group,
   input  logic       desc_valid,
   input  pkt_desc_t  desc,
   output logic       take,
   input  logic [7:0] fifo_data,
   output logic       rd_en,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic [1:0] out_ctrl
);
   localparam logic [7:0]  IDX_LAST = 8'(CELL_WIRE - 1);
   localparam logic [7:0]  IDX_PAY  = 8'(HDR_BYTES);
   localparam logic [10:0] CLEN     = 11'(CELL_BYTES);

   logic              busy, flag, last_cell;
   logic [7:0]        idx, byte_c;
   logic [5:0]        seq, total;
   logic [LEN_W-1:0]  remain;
   logic [4:0]        full;
   logic [10:0]       pad;
   logic [2:0]        og;
   logic [3:0]        prio;
   logic [6:0]        rem_c;
   logic [TAG_W-1:0]  tag, tag_nxt;
   logic [LINE_W-1:0] line, line_nxt;
   ctrl_e             ctrl_c;

   generate
      if ((MID_GROUPS & (MID_GROUPS - 1)) == 0) begin : g_tag_pow2
         assign tag_nxt = tag + 1'b1;
      end else begin : g_tag_mod
         assign tag_nxt = (tag == TAG_W'(MID_GROUPS - 1)) ? '0 : tag + 1'b1;
      end
      if ((LINES & (LINES - 1)) == 0) begin : g_line_pow2
         assign line_nxt = line + 1'b1;
      end else begin : g_line_mod
         assign line_nxt = (line == LINE_W'(LINES - 1)) ? '0 : line + 1'b1;
      end
   endgenerate

   assign rem_c     = desc.len[6:0];
   assign take      = !busy && desc_valid;
   assign rd_en     = busy && (idx >= IDX_PAY) && (remain != '0);
   assign last_cell = (seq == total);

   always_comb begin
      case (idx)
         8'd0:    byte_c = {1'b1, 3'(tag), prio};
         8'd1:    byte_c = {1'b1, og, prio};
         8'd2:    byte_c = {in_group, 4'(line)};
         8'd3:    byte_c = {seq, last_cell, 1'b0};
         8'd4:    byte_c = {in_group, CLEN[10:7]};
         8'd5:    byte_c = {CLEN[6:0], flag};
         8'd6:    byte_c = {full, pad[10:8]};
         8'd7:    byte_c = pad[7:0];
         default: byte_c = (remain != '0) ? fifo_data : FILL_BYTE;
      endcase
      if (idx == 8'd0)         ctrl_c = CT_SOP;
      else if (idx < IDX_PAY)  ctrl_c = CT_HDR;
      else if (idx == IDX_LAST) ctrl_c = CT_END;
      else                     ctrl_c = CT_PAY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; idx <= '0; seq <= '0; total <= '0; remain <= '0;
         full <= '0; pad <= '0; flag <= 1'b0; og <= '0; prio <= '0;
         tag <= '0; line <= '0;
         out_valid <= 1'b0; out_data <= '0; out_ctrl <= '0;
      end else begin
         out_valid <= busy;
         out_data  <= byte_c;
         out_ctrl  <= ctrl_c;
         if (take) begin
            busy   <= 1'b1;
            idx    <= '0;
            seq    <= 6'd1;
            remain <= desc.len;
            full   <= desc.len[LEN_W-1:7];
            flag   <= |rem_c;
            pad    <= (|rem_c) ? (CLEN - 11'(rem_c)) : '0;
            total  <= 6'(desc.len[LEN_W-1:7]) + 6'(|rem_c);
            og     <= desc.og;
            prio   <= desc.prio;
         end else if (busy) begin
            if (rd_en) remain <= remain - 1'b1;
            if (idx == IDX_LAST) begin
               idx  <= '0;
               tag  <= tag_nxt;
               line <= line_nxt;
               if (last_cell) busy <= 1'b0;
               else           seq  <= seq + 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cell_splitter.sv
module cell_splitter
   import cell_splitter_pkg::*;
#(
   parameter  int unsigned DEPTH      = 2048,
   parameter  int unsigned MAX_PKT    = 1518,
   parameter  int unsigned MID_GROUPS = 4,
   parameter  int unsigned LINES      = 8,
   localparam int unsigned FREE_W     = $clog2(DEPTH) + 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] in_group,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   input  logic [1:0] in_ctrl,
   output logic       in_ready,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic [1:0] out_ctrl
);
   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (DEPTH < MAX_PKT + CELL_BYTES) begin : g_small_depth
         $error("DEPTH must hold MAX_PKT plus one cell");
      end
      if (MAX_PKT < 1 || MAX_PKT > 31 * CELL_BYTES + CELL_BYTES - 1) begin : g_bad_max
         $error("MAX_PKT out of range of the 5-bit full-cell field");
      end
      if (MID_GROUPS < 2 || MID_GROUPS > 8) begin : g_bad_mid
         $error("MID_GROUPS must be 2..8");
      end
      if (LINES < 2 || LINES > 16) begin : g_bad_lines
         $error("LINES must be 2..16");
      end
   endgenerate

   logic              fifo_wr, fifo_rd, take, desc_valid;
   logic [7:0]        fifo_wdata, fifo_rdata;
   logic [FREE_W-1:0] fifo_free;
   pkt_desc_t         desc;

   cell_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fifo_wr), .wr_data(fifo_wdata),
      .rd_en(fifo_rd), .rd_data(fifo_rdata),
      .free(fifo_free)
   );

   pkt_ingress #(.FREE_W(FREE_W)) u_ingress (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_ctrl(in_ctrl),
      .in_ready(in_ready), .fifo_free(fifo_free),
      .wr_en(fifo_wr), .wr_data(fifo_wdata),
      .take(take), .desc_valid(desc_valid), .desc(desc)
   );

   cell_egress #(.MID_GROUPS(MID_GROUPS), .LINES(LINES)) u_egress (
      .clk(clk), .rst_n(rst_n), .in_group(in_group),
      .desc_valid(desc_valid), .desc(desc), .take(take),
      .fifo_data(fifo_rdata), .rd_en(fifo_rd),
      .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl)
   );
endmodule

// File: rtl/cell_splitter_chk.sv
module cell_splitter_chk #(
   parameter int unsigned DEPTH  = 2048,
   parameter int unsigned FREE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic [1:0]        out_ctrl,
   input logic [FREE_W-1:0] fifo_free,
   input logic              fifo_wr,
   input logic              fifo_rd
);
   // R3: never write into a full FIFO
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr |-> fifo_free != '0);

   // R3: never read from an empty FIFO
   a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> fifo_free != FREE_W'(DEPTH));

   // R2: the start byte is followed by a header byte
   a_r2_hdr_after_sop: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ctrl == 2'b11) |=> (out_valid && out_ctrl == 2'b01));

   // R2: after a last byte the stream either stops or opens a new cell
   a_r2_sop_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ctrl == 2'b10) |=> (!out_valid || out_ctrl == 2'b11));

   // R2: the stream only stops right after a last byte
   a_r2_stop_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> $past(out_ctrl) == 2'b10);
endmodule

bind cell_splitter cell_splitter_chk #(.DEPTH(DEPTH), .FREE_W(FREE_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .out_valid(out_valid), .out_ctrl(out_ctrl),
   .fifo_free(fifo_free), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd)
);

// File: tb/cell_splitter_tb.sv
`timescale 1ns/1ps
module cell_splitter_tb;
   localparam int MIDG = 4;
   localparam int NLIN = 6;
   localparam logic [3:0] GRP = 4'h9;
   localparam int NPKT = 8;
   // {length, expected cells, expected filler bytes}
   localparam int TAB [NPKT][3] = '{
      '{640, 5, 0}, '{384, 3, 0}, '{70, 1, 58}, '{429, 4, 83},
      '{1, 1, 127}, '{128, 1, 0}, '{129, 2, 127}, '{200, 2, 56}};

   logic clk = 0, rst_n = 0;
   logic in_valid = 0;
   logic [7:0] in_data = 0;
   logic [1:0] in_ctrl = 0;
   logic in_ready, out_valid;
   logic [7:0] out_data;
   logic [1:0] out_ctrl;

   int checks = 0, errors = 0, stalls = 0;
   int cells = 0, bi = 0, pi = 0, s = 1, tagm = 0, linem = 0;
   logic [7:0] cb [136];
   logic [1:0] cc [136];

   always #4 clk = ~clk;

   cell_splitter #(.DEPTH(1024), .MAX_PKT(896), .MID_GROUPS(MIDG), .LINES(NLIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_group(GRP),
      .in_valid(in_valid), .in_data(in_data), .in_ctrl(in_ctrl), .in_ready(in_ready),
      .out_valid(out_valid), .out_data(out_data), .out_ctrl(out_ctrl));

   function automatic logic [7:0] pat(int p, int i);
      return 8'(p * 29 + i * 7 + 3);
   endfunction

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] d, input logic [1:0] c);
      @(negedge clk);
      while (!in_ready) begin
         in_valid = 0;
         stalls++;
         @(negedge clk);
      end
      in_valid = 1; in_data = d; in_ctrl = c;
   endtask

   task automatic send_pkt(input int p);
      send({1'b0, 3'(p + 1), 4'(p * 5 + 2)}, 2'b11);
      for (int i = 0; i < TAB[p][0]; i++) begin
         if (p == 2 && i == 10) send(8'hA5, 2'b01);  // R1: header-coded byte inside a packet, dropped
         send(pat(p, i), (i == TAB[p][0] - 1) ? 2'b10 : 2'b00);
      end
      @(negedge clk);
      in_valid = 0;
   endtask

   task automatic check_cell();
      int L = TAB[pi][0];
      int nc = TAB[pi][1];
      int pd = TAB[pi][2];
      logic [2:0] og = 3'(pi + 1);
      logic [3:0] pr = 4'(pi * 5 + 2);
      bit ok;
      int ma = 0, me = 0;
      ok = (cc[0] == 2'b11) && (cc[135] == 2'b10);
      for (int k = 1; k < 8; k++) if (cc[k] != 2'b01) ok = 0;
      for (int k = 8; k < 135; k++) if (cc[k] != 2'b00) ok = 0;
      chk(ok, "R2", "control codes of cell", cc[0], 3);
      chk(cb[0] == {1'b1, 3'(tagm), pr}, "R4", "tag byte", cb[0], {1'b1, 3'(tagm), pr});
      chk(cb[1] == {1'b1, og, pr}, "R5", "route byte", cb[1], {1'b1, og, pr});
      chk(cb[2] == {GRP, 4'(linem)}, "R6", "group/line byte", cb[2], {GRP, 4'(linem)});
      chk(cb[3] == {6'(s), s == nc, 1'b0}, "R7", "sequence byte", cb[3], {6'(s), s == nc, 1'b0});
      chk(cb[4] == {GRP, 4'b0001}, "R8", "split byte 4", cb[4], {GRP, 4'b0001});
      chk(cb[5] == {7'b0, pd != 0}, "R8", "split byte 5", cb[5], {7'b0, pd != 0});
      chk(cb[6] == {5'(L / 128), 3'(pd >> 8)}, "R8", "split byte 6", cb[6], {5'(L / 128), 3'(pd >> 8)});
      chk(cb[7] == 8'(pd), "R8", "split byte 7", cb[7], pd);
      ok = 1;
      for (int j = 0; j < 128; j++) begin
         int idx = (s - 1) * 128 + j;
         logic [7:0] e = (idx < L) ? pat(pi, idx) : 8'hEE;
         if (ok && cb[8 + j] != e) begin ok = 0; ma = cb[8 + j]; me = e; end
      end
      chk(ok, (pi == 2) ? "R1" : "R9", "payload/filler", ma, me);
      if (pi == 7 && s == 1) chk(cb[0][6:4] == 3'd0 && cb[2][3:0] == 4'd0, "R10", "rotation restarts", cb[0], 8'h80);
      cells++;
      tagm = (tagm + 1) % MIDG;
      linem = (linem + 1) % NLIN;
      if (s == nc) begin pi++; s = 1; end else s++;
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         cb[bi] = out_data; cc[bi] = out_ctrl; bi++;
         if (bi == 136) begin check_cell(); bi = 0; end
      end
   end

   task automatic wait_cells(input int n);
      int k = 0;
      while (cells < n && k < 100000) begin @(negedge clk); k++; end
      if (cells < n) begin
         checks++; errors++;
         $display("FAIL R9 watchdog cells act=%0d exp=%0d", cells, n);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      chk(out_valid == 0, "R10", "out_valid in reset", out_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk(in_ready == 1, "R3", "in_ready after reset", in_ready, 1);
      // R1: bytes outside a packet are dropped
      send(8'h33, 2'b00); send(8'h44, 2'b10);
      @(negedge clk); in_valid = 0;
      repeat (5) @(negedge clk);
      chk(out_valid == 0, "R1", "no cell from stray bytes", out_valid, 0);
      for (int p = 0; p < 7; p++) send_pkt(p);
      wait_cells(17);
      repeat (300) @(negedge clk);
      chk(cells == 17 && bi == 0, "R9", "total cells", cells, 17);
      chk(stalls > 0, "R3", "in_ready held low while a packet waits", stalls, 1);
      rst_n = 0;
      repeat (3) @(negedge clk);
      chk(out_valid == 0, "R10", "out_valid after second reset", out_valid, 0);
      chk(in_ready == 1, "R10", "in_ready after second reset", in_ready, 1);
      pi = 7; s = 1; tagm = 0; linem = 0; bi = 0;
      rst_n = 1;
      send_pkt(7);
      wait_cells(19);
      repeat (20) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule